// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a single bus master and a word-addressed memory port. Each word in an alias window stands for one bit of backing memory. A read of an alias word returns the state of that bit as 0 or 1. A write of an alias word sets or clears that bit. The write is done as a read of the backing location followed by a write-back of the modified value. The read and the write-back use the same address and access size, and no other memory request is issued between them.

There are two alias windows. Each spans 32 MB. The window at 0x2200_0000 maps onto backing memory at 0x2000_0000, and the window at 0x4200_0000 maps onto 0x4000_0000. Byte, halfword and word accesses are supported. The access size sets how the backing address is aligned and how wide the bit index is. Any address outside both windows is passed to the memory port unchanged, as an ordinary access.

Both ports use a simple request/ready handshake. The master holds `mReq` and its fields until it sees a one-cycle `mReady` pulse, and the bridge holds `memReq` and its fields until the memory returns a one-cycle `memReady`. Data on both ports is right-justified and little-endian, so bit 0 is bit 0 of the lowest-addressed byte. Size codes are 0 for byte, 1 for halfword and 2 for word.

Top module: `bitband_bridge`

## Requirements
- R1: For a byte access inside an alias window, the backing address is the target base ORed with the low 25 address bits shifted right by 5, and the selected bit is (offset >> 2) & 7 of that byte.
- R2: For a halfword access (size code 1) inside an alias window, the backing address is the R1 address with bit 0 cleared, and the selected bit is (offset >> 2) & 15, counted little-endian across the two bytes.
- R3: For a word access (size code 2) inside an alias window, the backing address is the R1 address with bits 1:0 cleared, and the selected bit is (offset >> 2) & 31, counted little-endian across the four bytes.
- R4: An alias read returns 1 in bit 0 of `mRdata` when the selected backing bit is set and 0 when it is clear, and all other bits of `mRdata` are zero.
- R5: An alias write changes only the selected backing bit. Bit 0 of `mWdata` gives the new value (1 sets, 0 clears), and bits 31:1 of `mWdata` have no effect.
- R6: An alias write issues exactly two memory requests: a read, then a write to the same address at the same size. No other request comes between them, and `mReady` is raised only after the write-back has completed.
- R7: The second window (0x4200_0000 to 0x43FF_FFFF) maps onto 0x4000_0000 with the same rules as R1 to R3.
- R8: An access outside both windows issues exactly one memory request, with the master's address, size, direction and write data unchanged. A read returns the memory data unchanged.
- R9: While reset is asserted and just after it is released, `mReady` and `memReq` are low.
- R10: Once `memReq` is raised, it stays high with stable address, size and direction until `memReady` is seen.
- R11: `mReady` is a one-cycle pulse per master request and is never high while `memReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReq | input | 1 | Master request, held until mReady |
| mWrite | input | 1 | Master direction, 1 = write |
| mAddr | input | 32 | Master byte address |
| mSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mWdata | input | 32 | Master write data, right-justified |
| mReady | output | 1 | One-cycle completion pulse |
| mRdata | output | 32 | Read result, valid with mReady |
| memReq | output | 1 | Memory request, held until memReady |
| memWrite | output | 1 | Memory direction, 1 = write |
| memAddr | output | 32 | Memory byte address |
| memSize | output | 2 | Memory access size, same codes as mSize |
| memWdata | output | 32 | Memory write data, right-justified |
| memReady | input | 1 | Memory completion pulse |
| memRdata | input | 32 | Memory read data, valid with memReady |

## Verification
A wrong captured bit index or alignment would not stay hidden. The next alias read returns the wrong 0/1, and a backing word read through the pass-through path shows a neighbouring bit flipped, so the fault is visible within one master transaction. If the sequencer lost its place, it would show as a missing or extra memory request in the per-access request log, or as a stray `mReady` while `memReq` is high. The embedded checks catch that in the same cycle. A read-modify-write that mixes up its captured data shows up as more than one bit differing between the read value and the written value at the memory port, in the write-back cycle itself.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Access size codes shared by master and memory ports
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_t;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RMW_RD = 3'd1,
    ST_RMW_WR = 3'd2,
    ST_PASS   = 3'd3,
    ST_DONE   = 3'd4
  } bbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the master request and its decode
    logic loadRead;  // latch memory read data and form the result
  } dpStrobe_t;

endpackage

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 2,
  parameter int WIN_BITS    = 25,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              mWrite,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [1:0]        mSize,
  input  logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              aliasHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] mRdata
);

  // One alias word (4 bytes) per backing bit, 8 bits per backing byte
  localparam int ALIAS_SHIFT = 5;
  localparam int IDX_W       = $clog2(DATA_W);

  logic [NUM_REGIONS-1:0]             hitVec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] tgtVec;
  logic [ADDR_W-1:0]                  tgtSel;
  logic [ADDR_W-1:0]                  tgtAligned;
  logic [IDX_W-1:0]                   idxRaw;
  logic [IDX_W-1:0]                   idxMasked;

  // Per-region window decode
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    assign hitVec[g] = (mAddr[ADDR_W-1:WIN_BITS] == ALIAS_BASE[g][ADDR_W-1:WIN_BITS]);
    assign tgtVec[g] = TARGET_BASE[g] | ADDR_W'(mAddr[WIN_BITS-1:0] >> ALIAS_SHIFT);
  end

  always_comb begin
    tgtSel = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) tgtSel = tgtSel | tgtVec[i];
    end
  end

  assign aliasHit = |hitVec;
  assign idxRaw   = mAddr[IDX_W+1:2];

  // Alignment and bit-index width follow the access size
  always_comb begin
    unique case (mSize)
      SZ_BYTE: begin
        tgtAligned = tgtSel;
        idxMasked  = idxRaw & IDX_W'(7);
      end
      SZ_HALF: begin
        tgtAligned = {tgtSel[ADDR_W-1:1], 1'b0};
        idxMasked  = idxRaw & IDX_W'(15);
      end
      default: begin
        tgtAligned = {tgtSel[ADDR_W-1:2], 2'b00};
        idxMasked  = idxRaw;
      end
    endcase
  end

  // Latched request
  logic              regAlias;
  logic              regWrite;
  logic              regSetVal;
  logic [IDX_W-1:0]  regBitIdx;
  logic [ADDR_W-1:0] regAddr;
  logic [1:0]        regSize;
  logic [DATA_W-1:0] regWdata;
  logic [DATA_W-1:0] regData;
  logic [DATA_W-1:0] regResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAlias  <= 1'b0;
      regWrite  <= 1'b0;
      regSetVal <= 1'b0;
      regBitIdx <= '0;
      regAddr   <= '0;
      regSize   <= '0;
      regWdata  <= '0;
    end else if (strobe.capture) begin
      regAlias  <= aliasHit;
      regWrite  <= mWrite;
      regSetVal <= mWdata[0];
      regBitIdx <= idxMasked;
      regAddr   <= aliasHit ? tgtAligned : mAddr;
      regSize   <= mSize;
      regWdata  <= mWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regData   <= '0;
      regResult <= '0;
    end else if (strobe.loadRead) begin
      regData <= memRdata;
      if (regWrite)      regResult <= '0;
      else if (regAlias) regResult <= {{(DATA_W-1){1'b0}}, memRdata[regBitIdx]};
      else               regResult <= memRdata;
    end
  end

  // Read-modify-write value
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] rmwData;

  assign bitMask = DATA_W'(1) << regBitIdx;
  assign rmwData = regSetVal ? (regData | bitMask) : (regData & ~bitMask);

  assign memAddr  = regAddr;
  assign memSize  = regSize;
  assign memWdata = regAlias ? rmwData : regWdata;
  assign mRdata   = regResult;

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mReq,
  input  logic      mWrite,
  input  logic      aliasHit,
  input  logic      memReady,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWrite,
  output logic      mReady
);

  bbState_t state;
  bbState_t nextState;
  logic     isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.capture) isWrite <= mWrite;
    end
  end

  always_comb begin
    nextState       = state;
    strobe.capture  = 1'b0;
    strobe.loadRead = 1'b0;
    memReq          = 1'b0;
    memWrite        = 1'b0;
    mReady          = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (mReq) begin
          strobe.capture = 1'b1;
          nextState      = aliasHit ? ST_RMW_RD : ST_PASS;
        end
      end
      ST_RMW_RD: begin
        memReq = 1'b1;
        if (memReady) begin
          strobe.loadRead = 1'b1;
          nextState       = isWrite ? ST_RMW_WR : ST_DONE;
        end
      end
      ST_RMW_WR: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memReady) nextState = ST_DONE;
      end
      ST_PASS: begin
        memReq   = 1'b1;
        memWrite = isWrite;
        if (memReady) begin
          strobe.loadRead = 1'b1;
          nextState       = ST_DONE;
        end
      end
      ST_DONE: begin
        mReady    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 2,
  parameter int WIN_BITS    = 25,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mReq,
  input  logic              mWrite,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [1:0]        mSize,
  input  logic [DATA_W-1:0] mWdata,
  output logic              mReady,
  output logic [DATA_W-1:0] mRdata,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata
);

  dpStrobe_t strobe;
  logic      aliasHit;

  bb_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mReq     (mReq),
    .mWrite   (mWrite),
    .aliasHit (aliasHit),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWrite (memWrite),
    .mReady   (mReady)
  );

  bb_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_REGIONS (NUM_REGIONS),
    .WIN_BITS    (WIN_BITS),
    .ALIAS_BASE  (ALIAS_BASE),
    .TARGET_BASE (TARGET_BASE)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mWrite   (mWrite),
    .mAddr    (mAddr),
    .mSize    (mSize),
    .mWdata   (mWdata),
    .memRdata (memRdata),
    .aliasHit (aliasHit),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memWdata (memWdata),
    .mRdata   (mRdata)
  );

endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 2,
  parameter int WIN_BITS    = 25,
  parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000}
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       mReq,
  input logic                       mWrite,
  input logic [ADDR_W-1:WIN_BITS]   mAddrHi,
  input logic                       mReady,
  input logic [DATA_W-1:1]          mRdataHi,
  input logic                       memReq,
  input logic                       memWrite,
  input logic [ADDR_W-1:0]          memAddr,
  input logic [1:0]                 memSize,
  input logic [DATA_W-1:0]          memWdata,
  input logic                       memReady,
  input logic [DATA_W-1:0]          memRdata
);

  logic              inAlias;
  logic [ADDR_W-1:0] rdAddrCap;
  logic [DATA_W-1:0] rdDataCap;

  always_comb begin
    inAlias = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (mAddrHi == ALIAS_BASE[i][ADDR_W-1:WIN_BITS]) inAlias = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrCap <= '0;
      rdDataCap <= '0;
    end else if (memReq && memReady && !memWrite) begin
      rdAddrCap <= memAddr;
      rdDataCap <= memRdata;
    end
  end

  AST_READ_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    (mReady && mReq && !mWrite && inAlias) |-> (mRdataHi == '0)); // R4

  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && mReq && mWrite && inAlias) |-> ($countones(memWdata ^ rdDataCap) <= 1)); // R5

  AST_WRITEBACK_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && mReq && mWrite && inAlias) |-> (memAddr == rdAddrCap)); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memSize) && $stable(memWrite))); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    mReady |=> !mReady); // R11

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    mReady |-> !memReq); // R11

endmodule

bind bitband_bridge bb_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .NUM_REGIONS (NUM_REGIONS),
  .WIN_BITS    (WIN_BITS),
  .ALIAS_BASE  (ALIAS_BASE)
) i_bbChecker (
  .clk      (clk),
  .rstN     (rstN),
  .mReq     (mReq),
  .mWrite   (mWrite),
  .mAddrHi  (mAddr[ADDR_W-1:WIN_BITS]),
  .mReady   (mReady),
  .mRdataHi (mRdata[DATA_W-1:1]),
  .memReq   (memReq),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memSize  (memSize),
  .memWdata (memWdata),
  .memReady (memReady),
  .memRdata (memRdata)
);

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam int NVEC       = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mReq = 1'b0;
  logic        mWrite = 1'b0;
  logic [31:0] mAddr = '0;
  logic [1:0]  mSize = '0;
  logic [31:0] mWdata = '0;
  logic        mReady;
  logic [31:0] mRdata;
  logic        memReq;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [31:0] memWdata;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_bridge i_bitband_bridge (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr),
    .mSize(mSize), .mWdata(mWdata), .mReady(mReady), .mRdata(mRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata)
  );

  // ---------------- memory model with request log ----------------
  logic [7:0]  store  [0:511];
  logic [7:0]  shadow [0:511];
  logic [31:0] logAddr  [0:255];
  logic        logWrite [0:255];
  logic [1:0]  logSize  [0:255];
  int opTotal = 0;
  int latCnt  = 0;
  int holdErr = 0;
  logic        pendPrev = 1'b0;
  logic [31:0] addrPrev = '0;

  function automatic int sIdx(input logic [31:0] a);
    return int'({a[30], a[7:0]});
  endfunction

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    logic [31:0] rd;
    memReady <= 1'b0;
    if (memReq && !memReady) begin
      if (latCnt == MEM_LAT) begin
        latCnt   <= 0;
        memReady <= 1'b1;
        logAddr[opTotal]  <= memAddr;
        logWrite[opTotal] <= memWrite;
        logSize[opTotal]  <= memSize;
        opTotal <= opTotal + 1;
        rd = '0;
        for (int k = 0; k < 4; k++) begin
          if (k < nBytes(memSize)) begin
            if (memWrite) store[(sIdx(memAddr) + k) % 512] <= memWdata[8*k +: 8];
            rd[8*k +: 8] = store[(sIdx(memAddr) + k) % 512];
          end
        end
        if (!memWrite) memRdata <= rd;
      end else begin
        latCnt <= latCnt + 1;
      end
    end
    // request must hold its address while pending
    if (pendPrev && memReq && memAddr != addrPrev) holdErr <= holdErr + 1;
    if (pendPrev && !memReq) holdErr <= holdErr + 1;
    pendPrev <= memReq && !memReady;
    addrPrev <= memAddr;
  end

  // ---------------- check helpers ----------------
  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // reference mapping, written from the requirements
  function automatic void refMap(input logic [31:0] a, input logic [1:0] sz,
                                 output logic hit, output logic [31:0] ta, output int bitN);
    logic [31:0] aBase [2] = '{32'h2200_0000, 32'h4200_0000};
    logic [31:0] tBase [2] = '{32'h2000_0000, 32'h4000_0000};
    logic [31:0] off;
    hit = 1'b0; ta = a; bitN = 0;
    for (int r = 0; r < 2; r++) begin
      if (a >= aBase[r] && a < aBase[r] + 32'h0200_0000) begin
        off  = a - aBase[r];
        hit  = 1'b1;
        ta   = tBase[r] + off / 32;
        ta   = ta - (ta % nBytes(sz));
        bitN = int'((off / 4) % (8 * nBytes(sz)));
      end
    end
  endfunction

  logic [31:0] lastRd;
  int          lastOps;
  int          firstOp;

  task automatic doAccess(input logic w, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    int cyc;
    firstOp = opTotal;
    @(negedge clk);
    mReq = 1'b1; mWrite = w; mSize = sz; mAddr = a; mWdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!mReady && cyc < 200);
    chk(mReady, "R6 ready timeout", 32'(mReady), 32'd1);
    chk(!memReq, "R11 ready with memReq", 32'(memReq), 32'd0);
    lastRd  = mRdata;
    lastOps = opTotal - firstOp;
    mReq = 1'b0;
    @(negedge clk);
    chk(!mReady, "R11 ready pulse width", 32'(mReady), 32'd0);
  endtask

  function automatic logic [31:0] wordOf(input logic [31:0] a, input logic useShadow);
    logic [31:0] v;
    for (int k = 0; k < 4; k++)
      v[8*k +: 8] = useShadow ? shadow[(sIdx(a) + k) % 512] : store[(sIdx(a) + k) % 512];
    return v;
  endfunction

  // stimulus table: {write, size, address, write data}
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 32'h2200_01A4, 32'h0000_0000},  // R1 byte read
    {1'b1, 2'd0, 32'h2200_01A4, 32'h0000_0001},  // R1 byte set
    {1'b0, 2'd0, 32'h2200_01A4, 32'h0000_0000},  // R1 read back
    {1'b1, 2'd0, 32'h2200_01A4, 32'hFFFF_FFFE},  // R5 clear, upper data ignored
    {1'b0, 2'd0, 32'h2200_01A4, 32'h0000_0000},  // R5 read back
    {1'b0, 2'd1, 32'h2200_0A7C, 32'h0000_0000},  // R2 half read, bit 15
    {1'b1, 2'd1, 32'h2200_0A7C, 32'h0000_0001},  // R2 half set
    {1'b0, 2'd2, 32'h2200_1FF8, 32'h0000_0000},  // R3 word read, bit 30
    {1'b1, 2'd2, 32'h2200_1FF8, 32'h0000_0002},  // R3/R5 clear (lsb 0)
    {1'b0, 2'd0, 32'h4200_0044, 32'h0000_0000},  // R7 byte read
    {1'b1, 2'd2, 32'h4200_00FC, 32'h0000_0001},  // R7 word set, bit 31
    {1'b1, 2'd2, 32'h2000_0020, 32'hDEAD_BEEF},  // R8 pass write
    {1'b0, 2'd1, 32'h2000_0022, 32'h0000_0000},  // R8 pass half read
    {1'b0, 2'd0, 32'h4000_0007, 32'h0000_0000}   // R8 pass byte read
  };

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic        vW;
    logic [1:0]  vSz;
    logic [31:0] vA, vWd, ta, expV;
    logic        hit;
    int          bitN;
    string       tag;

    for (int i = 0; i < 512; i++) begin
      store[i]  = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end

    repeat (3) @(negedge clk);
    chk(!mReady && !memReq, "R9 during reset", {mReady, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!mReady && !memReq, "R9 after release", {mReady, memReq}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      {vW, vSz, vA, vWd} = VEC[i];
      refMap(vA, vSz, hit, ta, bitN);
      tag = !hit ? "R8" : (vA[30] ? "R7" : (vSz == 2'd0 ? "R1" : (vSz == 2'd1 ? "R2" : "R3")));
      doAccess(vW, vSz, vA, vWd);
      if (hit) begin
        if (vW) begin
          shadow[(sIdx(ta) + bitN / 8) % 512][bitN % 8] = vWd[0];
          chk(lastOps == 2, {tag, "/R6 op count"}, 32'(lastOps), 32'd2);
          chk(!logWrite[firstOp] && logWrite[firstOp+1], {tag, "/R6 read then write"},
              {logWrite[firstOp], logWrite[firstOp+1]}, 32'b01);
          chk(logAddr[firstOp+1] == ta && logAddr[firstOp] == ta, {tag, "/R6 rmw address"},
              logAddr[firstOp+1], ta);
          chk(logSize[firstOp+1] == vSz, {tag, "/R6 rmw size"}, 32'(logSize[firstOp+1]), 32'(vSz));
          chk(wordOf({ta[31:2], 2'b00}, 1'b0) == wordOf({ta[31:2], 2'b00}, 1'b1),
              {tag, "/R5 backing word"}, wordOf({ta[31:2], 2'b00}, 1'b0), wordOf({ta[31:2], 2'b00}, 1'b1));
        end else begin
          expV = {31'b0, shadow[(sIdx(ta) + bitN / 8) % 512][bitN % 8]};
          chk(lastRd == expV, {tag, "/R4 read bit"}, lastRd, expV);
          chk(lastOps == 1 && logAddr[firstOp] == ta, {tag, " read address"}, logAddr[firstOp], ta);
        end
      end else begin
        chk(lastOps == 1 && logAddr[firstOp] == vA && logSize[firstOp] == vSz && logWrite[firstOp] == vW,
            "R8 pass request", logAddr[firstOp], vA);
        if (vW) begin
          for (int k = 0; k < nBytes(vSz); k++) shadow[(sIdx(vA) + k) % 512] = vWd[8*k +: 8];
          chk(wordOf(vA, 1'b0) == vWd, "R8 pass write data", wordOf(vA, 1'b0), vWd);
        end else begin
          expV = '0;
          for (int k = 0; k < nBytes(vSz); k++) expV[8*k +: 8] = shadow[(sIdx(vA) + k) % 512];
          chk(lastRd == expV, "R8 pass read data", lastRd, expV);
        end
      end
    end

    // directed: bit 31 of the word set through the second window, seen directly
    doAccess(1'b0, 2'd0, 32'h4000_0007, 32'h0);
    chk(lastRd[7] == 1'b1, "R7 bit 31 lands in top byte", {24'b0, lastRd[7:0]}, 32'h80 | {24'b0, lastRd[6:0]});

    // directed: halfword bit 15 lands in bit 7 of the upper byte (little-endian)
    doAccess(1'b0, 2'd0, 32'h2000_0053, 32'h0);
    chk(lastRd[7] == 1'b1, "R2 bit 15 in upper byte", lastRd, {24'b0, 1'b1, lastRd[6:0]});

    // directed: write with upper data bits set but lsb 1, neighbours kept
    doAccess(1'b1, 2'd2, 32'h2200_1F80, 32'hFFFF_FFFF);
    refMap(32'h2200_1F80, 2'd2, hit, ta, bitN);
    shadow[(sIdx(ta) + bitN / 8) % 512][bitN % 8] = 1'b1;
    chk(wordOf(ta, 1'b0) == wordOf(ta, 1'b1), "R5 only selected bit set", wordOf(ta, 1'b0), wordOf(ta, 1'b1));

    chk(holdErr == 0, "R10 request held until ready", 32'(holdErr), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule